// File: doc/BRIEF.md
# Two-Source Cache Flush Controller

This block sits in front of a cache. It takes flush requests from a host register port and from a command engine. Each source gets one holding slot. Accepted requests go through a single fixed-priority arbiter, and the block drives one flush request/mode handshake toward the cache. When a flush completes, a one-cycle done pulse goes back to whichever source asked for that flush, even when requests from both sources overlap. A separate write-combiner flush can be requested from the host register, and it runs beside the cache flush.

While any slot is occupied or any flush (cache or write-combiner) is under way, the grant for regular cache accesses is held low. A second flush queued behind a running one therefore leaves no window in which an ordinary access can get through. Before a flush is sent to the cache, accesses that are still in flight (`acc_busy`) are allowed to drain.

Both request ports use valid/ready. A beat is taken on a cycle where valid and ready are both high. Ready drops while the slot a beat needs is still occupied, and the sender must then hold its valid and data steady. The flush interface toward the cache uses a level request: `fl_req` stays high with a stable mode until the cache returns a one-cycle `fl_ack` marking completion. The write-combiner interface pairs `wc_req` with `wc_ack` in the same way.

Top module: `flush_ctrl`

## Requirements
- R1: After reset the status word reads 0, `fl_req` and `wc_req` are low, no done pulse is present, and `acc_gnt` follows `acc_req`.
- R2: A host write with bit 0 set starts a cache flush that uses the mode in bits 2:1. Mode code 0 means invalidate all lines. All four mode codes reach `fl_mode` unchanged.
- R3: Status bit 0 reads 1 from the acceptance of a host flush until the done pulse for that flush. Host writes with bit 0 clear do not clear it.
- R4: A host write with bit 8 set raises `wc_req`. Status bit 8 reads 1 until `wc_ack`, and writes with bit 8 clear do not clear it.
- R5: A host write with bit 0 clear changes neither the mode read back in bits 2:1 nor the mode of an accepted host flush that is still waiting.
- R6: Each done pulse appears one cycle after `fl_ack`, only on the port of the source that issued that flush (`reg_done` for the host, `cmd_done` for commands). Both never pulse in the same cycle.
- R7: When both slots become occupied in the same cycle, the host flush is issued first.
- R8: The command word carries the mode in bits 1:0 and a defer flag in bit 2. A deferred command flush is not issued while `cmd_prior_idle` is low. A non-deferred one is issued regardless of `cmd_prior_idle`.
- R9: `acc_gnt` is low while any slot is occupied, a flush is active or a write-combiner flush is pending. This includes every cycle between two back-to-back flushes.
- R10: Neither `fl_req` nor `wc_req` rises while `acc_busy` is high.
- R11: A port whose slot is occupied holds ready low. Once the slot frees, the held beat is accepted and its mode is the one issued.
- R12: Once raised, `fl_req` stays high with a stable `fl_mode` until `fl_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_valid | input | 1 | Host register write valid |
| reg_wr_ready | output | 1 | Host register write ready |
| reg_wr_data | input | REG_W | Host write: bit 0 flush, bits 2:1 mode, bit 8 write-combiner flush |
| reg_rd_data | output | REG_W | Status word in the same layout |
| reg_done | output | 1 | Done pulse for a host flush |
| cmd_valid | input | 1 | Command flush valid |
| cmd_ready | output | 1 | Command flush ready |
| cmd_word | input | MODE_W+1 | Mode in bits 1:0, defer flag in bit 2 |
| cmd_prior_idle | input | 1 | All earlier commands have completed |
| cmd_done | output | 1 | Done pulse for a command flush |
| fl_req | output | 1 | Cache flush request (level) |
| fl_mode | output | MODE_W | Cache flush mode |
| fl_ack | input | 1 | Cache flush complete |
| wc_req | output | 1 | Write-combiner flush request |
| wc_ack | input | 1 | Write-combiner flush complete |
| acc_req | input | 1 | Regular access request |
| acc_busy | input | 1 | Regular accesses still in flight |
| acc_gnt | output | 1 | Regular access grant |

## Verification
The bench sweeps all four mode codes through both sources. It issues overlapping flushes from both sources, and then a host flush that lands while a command flush is running. A design that routed done by arrival order, rather than by owner, would pulse the wrong port. The bench holds `acc_req` high through every flush and checks each cycle in the gap between flushes, so a design that re-grants between flushes is caught. Zero writes and mode-only writes are placed in between; a design that let them clobber state would drop status bits early or send the wrong mode to the cache. Deferred flushes, back-pressure on an occupied slot, and draining while accesses are busy are each exercised as well.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_DRAIN = 2'd1,
    ARB_ISSUE = 2'd2
  } arb_state_e;

  localparam int SRC_HOST = 0;
  localparam int SRC_CMD  = 1;
  localparam int NUM_SRC  = 2;
endpackage

// File: rtl/flush_slot.sv
module flush_slot #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [MODE_W-1:0] push_mode,
  input  logic              push_defer,
  input  logic              pop,
  output logic              full,
  output logic [MODE_W-1:0] mode,
  output logic              defer
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      mode  <= '0;
      defer <= 1'b0;
    end else if (pop) begin
      full  <= 1'b0;
    end else if (push && !full) begin
      full  <= 1'b1;
      mode  <= push_mode;
      defer <= push_defer;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full && $stable(mode)); // R3
endmodule

// File: rtl/flush_arb.sv
module flush_arb
  import flush_pkg::*;
#(
  parameter int NSRC   = 2,
  parameter int MODE_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              elig,
  input  logic [NSRC-1:0][MODE_W-1:0]  slot_mode,
  input  logic                         acc_busy,
  input  logic                         fl_ack,
  output logic                         fl_req,
  output logic [MODE_W-1:0]            fl_mode,
  output logic [NSRC-1:0]              pop,
  output logic [NSRC-1:0]              done,
  output logic                         idle
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  arb_state_e       state;
  logic [IDX_W-1:0] owner, pick;
  logic             any;

  always_comb begin
    pick = '0;
    any  = |elig;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ARB_IDLE;
      owner   <= '0;
      fl_mode <= '0;
      done    <= '0;
    end else begin
      done <= '0;
      unique case (state)
        ARB_IDLE: if (any) begin
          owner   <= pick;
          fl_mode <= slot_mode[pick];
          state   <= ARB_DRAIN;
        end
        ARB_DRAIN: if (!acc_busy) state <= ARB_ISSUE;
        ARB_ISSUE: if (fl_ack) begin
          done[owner] <= 1'b1;
          state       <= ARB_IDLE;
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end

  always_comb begin
    pop = '0;
    if (state == ARB_ISSUE && fl_ack) pop[owner] = 1'b1;
  end

  assign fl_req = (state == ARB_ISSUE);
  assign idle   = (state == ARB_IDLE);

  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_ack |=> fl_req && $stable(fl_mode)); // R12
  AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_req) |-> !$past(acc_busy)); // R10
endmodule

// File: rtl/flush_wc.sv
module flush_wc (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic acc_busy,
  input  logic wc_ack,
  output logic busy,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      req  <= 1'b0;
    end else if (req && wc_ack) begin
      busy <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (push) busy <= 1'b1;
      if (busy && !acc_busy) req <= 1'b1;
    end
  end

  AST_WC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(req && wc_ack) |=> busy); // R4
  AST_WC_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !$past(acc_busy)); // R10
endmodule

// File: rtl/flush_ctrl.sv
module flush_ctrl
  import flush_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_valid,
  output logic              reg_wr_ready,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              reg_done,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [MODE_W:0]   cmd_word,
  input  logic              cmd_prior_idle,
  output logic              cmd_done,
  output logic              fl_req,
  output logic [MODE_W-1:0] fl_mode,
  input  logic              fl_ack,
  output logic              wc_req,
  input  logic              wc_ack,
  input  logic              acc_req,
  input  logic              acc_busy,
  output logic              acc_gnt
);
  localparam int BIT_REQ = 0;
  localparam int MODE_LO = 1;
  localparam int MODE_HI = MODE_W;
  localparam int BIT_WC  = 8;

  logic [NUM_SRC-1:0]             push, defer_in, pop, full, defer, elig, quiet, done;
  logic [NUM_SRC-1:0][MODE_W-1:0] mode_in, mode;
  logic                           host_take, wc_busy, arb_idle;
  logic                           unused_bits;

  assign unused_bits = ^{reg_wr_data[REG_W-1:BIT_WC+1], reg_wr_data[BIT_WC-1:MODE_HI+1]};

  assign reg_wr_ready = !(reg_wr_data[BIT_REQ] && full[SRC_HOST])
                     && !(reg_wr_data[BIT_WC] && wc_busy);
  assign host_take    = reg_wr_valid && reg_wr_ready;
  assign cmd_ready    = !full[SRC_CMD];

  assign push[SRC_HOST]     = host_take && reg_wr_data[BIT_REQ];
  assign mode_in[SRC_HOST]  = reg_wr_data[MODE_HI:MODE_LO];
  assign defer_in[SRC_HOST] = 1'b0;
  assign quiet[SRC_HOST]    = 1'b1;
  assign push[SRC_CMD]      = cmd_valid && cmd_ready;
  assign mode_in[SRC_CMD]   = cmd_word[MODE_W-1:0];
  assign defer_in[SRC_CMD]  = cmd_word[MODE_W];
  assign quiet[SRC_CMD]     = cmd_prior_idle;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    flush_slot #(.MODE_W(MODE_W)) i_slot (
      .clk(clk), .rst_n(rst_n), .push(push[g]), .push_mode(mode_in[g]),
      .push_defer(defer_in[g]), .pop(pop[g]), .full(full[g]),
      .mode(mode[g]), .defer(defer[g])
    );
    assign elig[g] = full[g] && (!defer[g] || quiet[g]);
  end

  flush_arb #(.NSRC(NUM_SRC), .MODE_W(MODE_W)) i_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .slot_mode(mode),
    .acc_busy(acc_busy), .fl_ack(fl_ack), .fl_req(fl_req),
    .fl_mode(fl_mode), .pop(pop), .done(done), .idle(arb_idle)
  );

  flush_wc i_wc (
    .clk(clk), .rst_n(rst_n), .push(host_take && reg_wr_data[BIT_WC]),
    .acc_busy(acc_busy), .wc_ack(wc_ack), .busy(wc_busy), .req(wc_req)
  );

  assign reg_done = done[SRC_HOST];
  assign cmd_done = done[SRC_CMD];
  assign acc_gnt  = acc_req && arb_idle && !(|full) && !wc_busy;

  always_comb begin
    reg_rd_data                  = '0;
    reg_rd_data[BIT_REQ]         = full[SRC_HOST];
    reg_rd_data[MODE_HI:MODE_LO] = mode[SRC_HOST];
    reg_rd_data[BIT_WC]          = wc_busy;
  end

  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> !fl_req && !wc_req); // R9
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && full[SRC_CMD] |-> !cmd_ready); // R11
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid && !reg_wr_data[BIT_REQ] && full[SRC_HOST]
    |=> reg_rd_data[MODE_HI:MODE_LO] == $past(reg_rd_data[MODE_HI:MODE_LO])); // R5
endmodule

// File: tb/test_flush_ctrl.sv
module test_flush_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr_valid = 0, reg_wr_ready, reg_done;
  logic [15:0] reg_wr_data = '0, reg_rd_data;
  logic        cmd_valid = 0, cmd_ready, cmd_prior_idle = 1, cmd_done;
  logic [2:0]  cmd_word = '0;
  logic        fl_req, fl_ack = 0, wc_req, wc_ack = 0;
  logic [1:0]  fl_mode;
  logic        acc_req = 1, acc_busy = 0, acc_gnt;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  flush_ctrl i_flush_ctrl (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] d);
    reg_wr_valid = 1; reg_wr_data = d;
    while (!reg_wr_ready) @(negedge clk);
    @(negedge clk); reg_wr_valid = 0; reg_wr_data = '0;
  endtask

  task automatic wr_cmd(input logic [1:0] m, input logic dfr);
    cmd_valid = 1; cmd_word = {dfr, m};
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 0;
  endtask

  // Waits for the flush, checks mode and hold, acks, checks done routing.
  task automatic serve(input logic [1:0] m, input int src);
    int n = 0;
    while (!fl_req && n < 60) begin
      chk(acc_gnt == 0, "R9 gap grant", acc_gnt, 0);
      @(negedge clk); n++;
    end
    chk(fl_req == 1, "R2 flush issued", fl_req, 1);
    chk(fl_mode == m, "R2 mode at cache", fl_mode, m);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(fl_req && fl_mode == m, "R12 request held", fl_mode, m);
      chk(acc_gnt == 0, "R9 grant during flush", acc_gnt, 0);
    end
    fl_ack = 1; @(negedge clk); fl_ack = 0;
    chk(reg_done == (src == 0), "R6 reg_done routing", reg_done, src == 0);
    chk(cmd_done == (src == 1), "R6 cmd_done routing", cmd_done, src == 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(reg_rd_data == 0, "R1 status", reg_rd_data, 0);
    chk(!fl_req && !wc_req, "R1 requests", fl_req, 0);
    chk(!reg_done && !cmd_done, "R1 done", reg_done, 0);
    chk(acc_gnt == 1, "R1 grant follows", acc_gnt, 1);

    // Host sweep over all modes with zero and mode-only writes (R2 R3 R5)
    for (int m = 0; m < 4; m++) begin
      acc_busy = (m == 1);
      wr_reg(16'((m << 1) | 1));
      chk(reg_rd_data[0] == 1, "R3 status set", reg_rd_data[0], 1);
      wr_reg(16'h0000);
      chk(reg_rd_data[0] == 1, "R3 zero write keeps", reg_rd_data[0], 1);
      wr_reg(16'(((m ^ 3) << 1)));
      chk(reg_rd_data[2:1] == 2'(m), "R5 mode readback", reg_rd_data[2:1], m);
      if (m == 1) begin
        repeat (5) @(negedge clk);
        chk(fl_req == 0, "R10 no issue while busy", fl_req, 0);
        acc_busy = 0;
      end
      serve(2'(m), 0);
      chk(reg_rd_data[0] == 0, "R3 status clear at done", reg_rd_data[0], 0);
      chk(acc_gnt == 1, "R9 grant returns", acc_gnt, 1);
    end

    // Command sweep, prior_idle low, not deferred (R8)
    cmd_prior_idle = 0;
    for (int m = 0; m < 4; m++) begin
      wr_cmd(2'(m), 1'b0);
      serve(2'(m), 1);
    end

    // Both in the same cycle: host first (R7)
    cmd_prior_idle = 1;
    reg_wr_valid = 1; reg_wr_data = 16'h0003; cmd_valid = 1; cmd_word = 3'b010;
    @(negedge clk); reg_wr_valid = 0; cmd_valid = 0;
    serve(2'd1, 0);
    serve(2'd2, 1);

    // Host flush arrives while command flush runs (R6 R9)
    wr_cmd(2'd3, 1'b0);
    wr_reg(16'h0005);
    serve(2'd3, 1);
    chk(reg_rd_data[0] == 1, "R3 host still pending", reg_rd_data[0], 1);
    serve(2'd2, 0);

    // Deferred flush and back-pressure (R8 R11)
    cmd_prior_idle = 0;
    wr_cmd(2'd3, 1'b1);
    cmd_valid = 1; cmd_word = 3'b001;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(fl_req == 0, "R8 deferred held", fl_req, 0);
      chk(cmd_ready == 0, "R11 ready low", cmd_ready, 0);
    end
    cmd_prior_idle = 1;
    serve(2'd3, 1);
    chk(cmd_ready == 1, "R11 ready after free", cmd_ready, 1);
    @(negedge clk); cmd_valid = 0;
    serve(2'd1, 1);

    // Write-combiner flush (R4 R9 R10)
    acc_busy = 1;
    wr_reg(16'h0100);
    chk(reg_rd_data[8] == 1, "R4 wc status", reg_rd_data[8], 1);
    chk(acc_gnt == 0, "R9 grant off for wc", acc_gnt, 0);
    repeat (3) @(negedge clk);
    chk(wc_req == 0, "R10 wc waits drain", wc_req, 0);
    acc_busy = 0;
    @(negedge clk);
    chk(wc_req == 1, "R4 wc request", wc_req, 1);
    wr_reg(16'h0000);
    chk(reg_rd_data[8] == 1, "R4 zero write keeps wc", reg_rd_data[8], 1);
    wc_ack = 1; @(negedge clk); wc_ack = 0;
    chk(reg_rd_data[8] == 0 && wc_req == 0, "R4 wc done", reg_rd_data[8], 0);
    chk(acc_gnt == 1, "R9 grant after wc", acc_gnt, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule